// File: doc/BRIEF.md
# Interrupt Concentrator with Bank Summaries

The block merges interrupt requests from several GPIO banks and several on-chip peripherals into one pending word and drives a single request line to the host processor. The host treats that line as rising-edge sensitive. Each GPIO bank supplies one level summary line. Its pending bit follows that line directly, and the bank's own logic clears it. Each peripheral supplies a request that is caught in a sticky pending bit. The host clears that bit by writing a one to it.

A per-source enable word and one global enable decide which pending bits may raise the output. A set enable bit lets its source through. The host works through a small 16-bit register port with a write strobe, a 2-bit register select and combinational read data. A write to the pending register forces the output low for one cycle. If enabled work is still pending after that write, the output then rises again, so the host sees a new rising edge and does not miss a request.

Top module: `irqsum_top`

## Requirements
- R1: After reset, every peripheral pending bit and every enable bit is 0, the global enable is 0, and `irq_o` is 0.
- R2: Reading register select 0 (pending) returns the live bank request lines in bits 0 to 3, in the same cycle, with bank 0 in bit 0. A write to that register does not change these bits.
- R3: A high peripheral request sets its pending bit at the next clock edge. Peripheral k appears in bit 4+k. The bit stays set after the request falls.
- R4: A write to register select 0 clears every peripheral pending bit whose data bit is 1. Bits written as 0 are left unchanged. Data bits 0 to 3 and 10 to 15 have no effect.
- R5: When a peripheral request and a clear of the same bit arrive in the same cycle, the bit stays set.
- R6: Register select 1 (enable) holds a per-source enable in bits 0 to 9, where 1 enables the source, and the global enable in bit 15. The register reads back what was written, and bits 10 to 14 read 0.
- R7: When no pending-register write took place in the previous cycle, `irq_o` is 1 one cycle after some pending bit has its enable set while the global enable is 1.
- R8: `irq_o` stays 0 when the global enable is 0, or when every pending bit is disabled.
- R9: In the cycle after any write to the pending register, `irq_o` is 0. In the cycle after that, it is 1 again if enabled work is still pending.
- R10: Register selects 2 and 3 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_req | input | 4 | Live summary request from each GPIO bank |
| periph_req | input | 6 | Request from each peripheral |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pending, 1 enable, 2 and 3 reserved |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request to the host, rising-edge sensitive |

## Verification
Read data is combinational, so the bench drives the select on the falling clock edge and samples the read data a moment later in the same low phase.

A peripheral request is visible in the pending register after one rising edge. Because bank bits are live, they are visible immediately. `irq_o` is registered, so it reflects pending, enable and global-enable state one edge later. A peripheral request therefore reaches `irq_o` two edges after it is driven.

The bench waits out that full path before it compares `irq_o` in each sweep step. It checks the one-cycle low gap at the first falling edge after a pending-register write, and the re-raised output at the falling edge after that.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_ENAB = 2'd1,
    REG_RSV2 = 2'd2,
    REG_RSV3 = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqsum_latch.sv
module irqsum_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign stat_o[i] = q;

    a_r3_set_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q);
    a_r3_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i[i]) |=> q);
    a_r5_req_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && clr_i[i]) |=> q);
  end
endmodule

// File: rtl/irqsum_regs.sv
module irqsum_regs
  import irqsum_pkg::*;
#(
  parameter int NB = 4,
  parameter int NP = 6,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NB+NP-1:0]  pend_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NB+NP-1:0]  en_o,
  output logic              glob_o,
  output logic [NP-1:0]     clr_o,
  output logic              pend_wr_o
);
  localparam int NSRC = NB + NP;
  localparam int GBIT = DW - 1;

  reg_sel_e sel;
  logic [NSRC-1:0] en_q;
  logic glob_q;
  logic en_wr;
  logic unused_wbits;

  assign sel          = reg_sel_e'(sel_i);
  assign en_wr        = wr_i && (sel == REG_ENAB);
  assign pend_wr_o    = wr_i && (sel == REG_PEND);
  assign clr_o        = pend_wr_o ? wdata_i[NSRC-1:NB] : '0;
  assign unused_wbits = ^wdata_i[GBIT-1:NSRC] ^ ^wdata_i[NB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      glob_q <= 1'b0;
    end else if (en_wr) begin
      en_q   <= wdata_i[NSRC-1:0];
      glob_q <= wdata_i[GBIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_PEND: rdata_o[NSRC-1:0] = pend_i;
      REG_ENAB: begin
        rdata_o[NSRC-1:0] = en_q;
        rdata_o[GBIT]     = glob_q;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign glob_o = glob_q;

  a_r6_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(wdata_i[NSRC-1:0]) && glob_q == $past(wdata_i[GBIT])));
  a_r10_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> ($stable(en_q) && $stable(glob_q)));
endmodule

// File: rtl/irqsum_out.sv
module irqsum_out #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            glob_i,
  input  logic            gap_i,
  output logic            irq_o
);
  logic live;
  logic irq_q;

  assign live = glob_i && |(pend_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= live && !gap_i;
  end
  assign irq_o = irq_q;

  a_r9_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    gap_i |=> !irq_o);
  a_r8_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_i |=> !irq_o);
  a_r8_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);
  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_i && ((pend_i & en_i) != '0) && !gap_i) |=> irq_o);
endmodule

// File: rtl/irqsum_top.sv
module irqsum_top #(
  parameter int NB = 4,
  parameter int NP = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_req,
  input  logic [NP-1:0] periph_req,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int NSRC = NB + NP;

  logic [NP-1:0]   periph_stat;
  logic [NP-1:0]   clr;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] en;
  logic            glob;
  logic            pend_wr;

  assign pend = {periph_stat, bank_req};

  irqsum_latch #(.N(NP)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (periph_req),
    .clr_i  (clr),
    .stat_o (periph_stat)
  );

  irqsum_regs #(.NB(NB), .NP(NP), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .sel_i     (reg_sel),
    .wdata_i   (reg_wdata),
    .pend_i    (pend),
    .rdata_o   (reg_rdata),
    .en_o      (en),
    .glob_o    (glob),
    .clr_o     (clr),
    .pend_wr_o (pend_wr)
  );

  irqsum_out #(.NSRC(NSRC)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .en_i   (en),
    .glob_i (glob),
    .gap_i  (pend_wr),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/irqsum_top_bench.sv
module irqsum_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bank_req = '0;
  logic [5:0]  periph_req = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqsum_top u_irqsum_top (
    .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .periph_req(periph_req),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check("R1 pending", d, 16'h0000);
    rd(2'd1, d); check("R1 enable", d, 16'h0000);
    check("R1 irq", {15'd0, irq_o}, 16'h0000);

    // R2 live bank bits, unaffected by pending writes
    bank_req = 4'b1010;
    rd(2'd0, d); check("R2 live bank", d, 16'h000A);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d); check("R2 bank after write", d, 16'h000A);
    bank_req = 4'b0000;
    rd(2'd0, d); check("R2 bank drop", d, 16'h0000);

    // R3 sticky peripheral bits
    periph_req = 6'b000101;
    @(negedge clk);
    periph_req = '0;
    rd(2'd0, d); check("R3 latched", d, 16'h0050);
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R3 held", d, 16'h0050);

    // R4 partial W1C, bank and high data bits ignored
    wr(2'd0, 16'hFC1F);
    rd(2'd0, d); check("R4 partial clear", d, 16'h0040);
    wr(2'd0, 16'h0040);
    rd(2'd0, d); check("R4 full clear", d, 16'h0000);

    // R5 request wins over clear
    @(negedge clk);
    periph_req = 6'b100000; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0200;
    @(negedge clk);
    periph_req = '0; reg_wr = 1'b0;
    rd(2'd0, d); check("R5 set wins", d, 16'h0200);

    // R6 enable readback, unused bits zero
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); check("R6 readback", d, 16'h83FF);

    // R7 raise, R9 gap and re-raise
    @(negedge clk);
    check("R7 raised", {15'd0, irq_o}, 16'h0001);
    wr(2'd0, 16'h0000);
    check("R9 gap low", {15'd0, irq_o}, 16'h0000);
    @(negedge clk);
    check("R9 re-raise", {15'd0, irq_o}, 16'h0001);
    wr(2'd0, 16'h0200);
    @(negedge clk);
    check("R9 stays low once clear", {15'd0, irq_o}, 16'h0000);

    // R10 reserved registers
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'hFFFF);
    rd(2'd2, d); check("R10 reserved 2", d, 16'h0000);
    rd(2'd3, d); check("R10 reserved 3", d, 16'h0000);
    rd(2'd1, d); check("R10 enable untouched", d, 16'h83FF);
    rd(2'd0, d); check("R10 pending untouched", d, 16'h0000);

    // Sweep: R2 R3 R6 R7 R8 over every pending pattern
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] p;
      logic [9:0] m;
      logic       g;
      logic       e;
      p = i[9:0];
      m = 10'((i * 37 + 5) & 10'h3FF);
      g = i[0] ^ i[5] ^ i[8];
      e = g && ((p & m) != 10'd0);
      @(negedge clk);
      bank_req = p[3:0];
      reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h03F0;
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = {g, 5'd0, m};
      @(negedge clk);
      reg_wr = 1'b0;
      periph_req = p[9:4];
      @(negedge clk);
      periph_req = '0;
      @(negedge clk);
      rd(2'd0, d); check("R3 sweep pending", d, {6'd0, p});
      check(e ? "R7 sweep irq" : "R8 sweep irq", {15'd0, irq_o}, {15'd0, e});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule